// File: doc/BRIEF.md
# Chip-Select Gated Registered Fanout Buffer

This block is a register stage placed on DRAM address and command wires. On each rising clock edge it captures a bank of data bits and drives every captured bit onto two identical output copies, A and B, so that each copy can drive its own half of a module load. The data bits are gated by two active-low select inputs, a primary select and a secondary select. The data registers take new values only when at least one of the two selects is low, and keep their contents when both are high.

Two control bits, a clock-enable and a termination-enable, are not gated. They are registered on every edge. A registered copy of the primary select is also driven out in both copies; the secondary select has no effect on it. An active-low reset clears every register at once, without waiting for a clock edge, and overrides the gating. Its release passes through a synchronizer, so the first capture after reset comes on a known clock edge.

Top module: `csgate_fanout_reg`

## Requirements
- R1: Outputs change only on a rising clock edge. Input changes between edges do not reach any output until the next rising edge.
- R2: When `sel_pri_n` is 0 or `sel_sec_n` is 0 at a rising edge, both data copies take the value of `d_in` sampled at that edge.
- R3: When `sel_pri_n` and `sel_sec_n` are both 1 at a rising edge, both data copies keep their previous value.
- R4: `q_cke_a`/`q_cke_b` and `q_odt_a`/`q_odt_b` take `cke_in` and `odt_in` at every rising edge, whatever the select inputs are.
- R5: `q_sel_n_a`/`q_sel_n_b` take `sel_pri_n` at every rising edge. `sel_sec_n` never affects them.
- R6: While `rst_n` is 0, every output is 0. This takes effect as soon as `rst_n` falls, with no clock edge needed, and it holds across clock edges whatever the select inputs are.
- R7: The A and B copies of every registered bit are always equal.
- R8: After `rst_n` rises, every output stays 0 for SYNC_STAGES rising edges. The first capture happens on rising edge SYNC_STAGES+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized |
| sel_pri_n | input | 1 | Primary chip select, active low; gates data and is registered out |
| sel_sec_n | input | 1 | Secondary chip select, active low; gates data only |
| d_in | input | DATA_W | Gated data lanes |
| cke_in | input | 1 | Clock-enable bit, registered without gating |
| odt_in | input | 1 | Termination-enable bit, registered without gating |
| q_a | output | DATA_W | Data copy A |
| q_b | output | DATA_W | Data copy B |
| q_sel_n_a | output | 1 | Registered primary select, copy A |
| q_sel_n_b | output | 1 | Registered primary select, copy B |
| q_cke_a | output | 1 | Registered clock-enable, copy A |
| q_cke_b | output | 1 | Registered clock-enable, copy B |
| q_odt_a | output | 1 | Registered termination-enable, copy A |
| q_odt_b | output | 1 | Registered termination-enable, copy B |

## Verification
The bench builds the block with DATA_W = 11, the lane count of the parity-capable variant, and with SYNC_STAGES = 2. The 11-bit width lets alternating, all-ones, single-low-bit and single-high-bit patterns show any lane that is dropped or swapped between the copies. Two synchronizer stages make the release window short enough that the bench can check each edge of it: the outputs stay low through the two release edges and capture on the third. The vector table walks all four select combinations, with hold cycles placed between loads, so that gated and ungated bits can be seen going their separate ways.

// File: rtl/csgate_fanout_pkg.sv
package csgate_fanout_pkg;
   localparam int NUM_COPIES = 2;

   typedef struct packed {
      logic sel_n;
      logic cke;
      logic odt;
   } ctl_bits_t;
endpackage

// File: rtl/fbuf_rst_sync.sv
module fbuf_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n_async,
   output logic rst_n_sync
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("fbuf_rst_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n_async) begin
      if (!rst_n_async) chain <= '0;
      else              chain <= {chain[STAGES-2:0], 1'b1};
   end

   assign rst_n_sync = chain[STAGES-1];

   // R8
   sync_hold_low_chk: assert property (@(posedge clk)
      !rst_n_async |=> !rst_n_sync);
endmodule

// File: rtl/fbuf_lane_bank.sv
module fbuf_lane_bank #(
   parameter int WIDTH = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_en,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q_a,
   output logic [WIDTH-1:0] q_b
);
   import csgate_fanout_pkg::*;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("fbuf_lane_bank: WIDTH must be at least 1");
      end
      for (genvar c = 0; c < NUM_COPIES; c++) begin : g_copy
         logic [WIDTH-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       r <= '0;
            else if (load_en) r <= d;
         end
      end
   endgenerate

   assign q_a = g_copy[0].r;
   assign q_b = g_copy[1].r;

   // R2
   lane_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> (q_a == $past(d)));
   // R3
   lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_en |=> $stable(q_a));
   // R7
   lane_copy_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q_a == q_b);
endmodule

// File: rtl/fbuf_ctl_bank.sv
module fbuf_ctl_bank
   import csgate_fanout_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  ctl_bits_t ctl_in,
   output ctl_bits_t ctl_a,
   output ctl_bits_t ctl_b
);
   generate
      for (genvar c = 0; c < NUM_COPIES; c++) begin : g_copy
         ctl_bits_t r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= '0;
            else        r <= ctl_in;
         end
      end
   endgenerate

   assign ctl_a = g_copy[0].r;
   assign ctl_b = g_copy[1].r;

   // R4
   ctl_enable_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (ctl_a.cke == $past(ctl_in.cke)) && (ctl_a.odt == $past(ctl_in.odt)));
   // R5
   ctl_sel_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (ctl_b.sel_n == $past(ctl_in.sel_n)));
   // R7
   ctl_copy_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_a == ctl_b);
endmodule

// File: rtl/csgate_fanout_reg.sv
module csgate_fanout_reg #(
   parameter int DATA_W      = 11,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_pri_n,
   input  logic              sel_sec_n,
   input  logic [DATA_W-1:0] d_in,
   input  logic              cke_in,
   input  logic              odt_in,
   output logic [DATA_W-1:0] q_a,
   output logic [DATA_W-1:0] q_b,
   output logic              q_sel_n_a,
   output logic              q_sel_n_b,
   output logic              q_cke_a,
   output logic              q_cke_b,
   output logic              q_odt_a,
   output logic              q_odt_b
);
   import csgate_fanout_pkg::*;

   logic      rst_n_int;
   logic      load_en;
   ctl_bits_t ctl_in;
   ctl_bits_t ctl_a;
   ctl_bits_t ctl_b;

   fbuf_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
      .clk         (clk),
      .rst_n_async (rst_n),
      .rst_n_sync  (rst_n_int)
   );

   assign load_en = !(sel_pri_n && sel_sec_n);

   fbuf_lane_bank #(.WIDTH(DATA_W)) u_lanes (
      .clk     (clk),
      .rst_n   (rst_n_int),
      .load_en (load_en),
      .d       (d_in),
      .q_a     (q_a),
      .q_b     (q_b)
   );

   assign ctl_in = '{sel_n: sel_pri_n, cke: cke_in, odt: odt_in};

   fbuf_ctl_bank u_ctl (
      .clk    (clk),
      .rst_n  (rst_n_int),
      .ctl_in (ctl_in),
      .ctl_a  (ctl_a),
      .ctl_b  (ctl_b)
   );

   assign q_sel_n_a = ctl_a.sel_n;
   assign q_sel_n_b = ctl_b.sel_n;
   assign q_cke_a   = ctl_a.cke;
   assign q_cke_b   = ctl_b.cke;
   assign q_odt_a   = ctl_a.odt;
   assign q_odt_b   = ctl_b.odt;

   // R6
   reset_clears_chk: assert property (@(posedge clk)
      !rst_n |-> (q_a == '0) && (q_b == '0) && !q_sel_n_a && !q_cke_b && !q_odt_a);
endmodule

// File: tb/csgate_fanout_reg_tb_top.sv
module csgate_fanout_reg_tb_top;
   localparam int W = 11;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         sel_pri_n = 1'b1, sel_sec_n = 1'b1;
   logic [W-1:0] d_in = '0;
   logic         cke_in = 1'b0, odt_in = 1'b0;
   logic [W-1:0] q_a, q_b;
   logic         q_sel_n_a, q_sel_n_b, q_cke_a, q_cke_b, q_odt_a, q_odt_b;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   always #2.5 clk = ~clk;

   csgate_fanout_reg #(.DATA_W(W), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .sel_pri_n(sel_pri_n), .sel_sec_n(sel_sec_n),
      .d_in(d_in), .cke_in(cke_in), .odt_in(odt_in),
      .q_a(q_a), .q_b(q_b), .q_sel_n_a(q_sel_n_a), .q_sel_n_b(q_sel_n_b),
      .q_cke_a(q_cke_a), .q_cke_b(q_cke_b), .q_odt_a(q_odt_a), .q_odt_b(q_odt_b)
   );

   // bits: [28] sel_pri_n [27] sel_sec_n [26] cke [25] odt [24:14] d
   //       [13:3] expected q [2] expected sel_n [1] expected cke [0] expected odt
   localparam logic [28:0] VEC [8] = '{
      {1'b0, 1'b0, 1'b1, 1'b0, 11'h5A5, 11'h5A5, 1'b0, 1'b1, 1'b0},
      {1'b0, 1'b1, 1'b0, 1'b1, 11'h3C3, 11'h3C3, 1'b0, 1'b0, 1'b1},
      {1'b1, 1'b0, 1'b1, 1'b1, 11'h7FF, 11'h7FF, 1'b1, 1'b1, 1'b1},
      {1'b1, 1'b1, 1'b0, 1'b0, 11'h000, 11'h7FF, 1'b1, 1'b0, 1'b0},
      {1'b1, 1'b1, 1'b1, 1'b0, 11'h123, 11'h7FF, 1'b1, 1'b1, 1'b0},
      {1'b0, 1'b1, 1'b1, 1'b1, 11'h001, 11'h001, 1'b0, 1'b1, 1'b1},
      {1'b1, 1'b1, 1'b0, 1'b1, 11'h400, 11'h001, 1'b1, 1'b0, 1'b1},
      {1'b1, 1'b0, 1'b0, 1'b0, 11'h400, 11'h400, 1'b1, 1'b0, 1'b0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic chk_all(input string req, input logic [W-1:0] eq,
                          input logic es, input logic ec, input logic eo);
      chk(req, {21'd0, q_a}, {21'd0, eq});
      chk({req, " R7"}, {21'd0, q_b}, {21'd0, q_a});
      chk(req, {29'd0, q_sel_n_a, q_sel_n_b, q_cke_a}, {29'd0, es, es, ec});
      chk(req, {30'd0, q_cke_b, q_odt_a}, {30'd0, ec, eo});
      chk({req, " R7"}, {31'd0, q_odt_b}, {31'd0, q_odt_a});
   endtask

   initial begin
      // reset state with live inputs
      sel_pri_n = 1'b0; d_in = 11'h155; cke_in = 1'b1; odt_in = 1'b1;
      repeat (3) @(negedge clk);
      chk_all("R6 reset state", '0, 1'b0, 1'b0, 1'b0);

      // R8 synchronized release: drive new data, release mid-cycle
      d_in = 11'h2AA;
      rst_n = 1'b1;
      @(negedge clk);
      chk_all("R8 release edge 1", '0, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      chk_all("R8 release edge 2", '0, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      chk_all("R8 first capture", 11'h2AA, 1'b0, 1'b1, 1'b1);

      // table walk: R2 R3 R4 R5
      for (int i = 0; i < 8; i++) begin
         sel_pri_n = VEC[i][28];
         sel_sec_n = VEC[i][27];
         cke_in    = VEC[i][26];
         odt_in    = VEC[i][25];
         d_in      = VEC[i][24:14];
         @(negedge clk);
         chk_all($sformatf("R2/R3/R4/R5 vector %0d", i),
                 VEC[i][13:3], VEC[i][2], VEC[i][1], VEC[i][0]);
      end

      // R1: mid-cycle input change is not seen until the edge
      sel_pri_n = 1'b0; sel_sec_n = 1'b0; d_in = 11'h0F0; cke_in = 1'b1; odt_in = 1'b1;
      #1.5;
      chk_all("R1 before edge", 11'h400, 1'b1, 1'b0, 1'b0);
      @(negedge clk);
      chk_all("R1 after edge", 11'h0F0, 1'b0, 1'b1, 1'b1);

      // R6: asynchronous reset mid-cycle, then held across an edge with selects active
      #1.0;
      rst_n = 1'b0;
      #0.5;
      chk_all("R6 async clear", '0, 1'b0, 1'b0, 1'b0);
      d_in = 11'h7FF;
      @(negedge clk);
      chk_all("R6 priority over select", '0, 1'b0, 1'b0, 1'b0);

      // R8 again after mid-stream reset, secondary select only
      sel_pri_n = 1'b1; sel_sec_n = 1'b0; d_in = 11'h2D2; cke_in = 1'b0; odt_in = 1'b1;
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk_all("R8 held low after reset", '0, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      chk_all("R8 capture after reset", 11'h2D2, 1'b1, 1'b0, 1'b1);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(5ns * 20000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule